// File: doc/BRIEF.md
# Pattern-Independent Frame-Lock Deserializer

This block sits behind a serial receiver front end and takes the recovered line one bit per fast-clock cycle. Each line frame is 28 bits long. A start marker at 1 and an end marker at 0 bracket a 26-bit payload, and the payload carries two overhead bits and 24 scrambled data bits. The block finds the frame boundary without a training sequence, a sync character or a reference clock. It tries one bit offset after another. An offset is accepted once the marker pair appears at that offset in eight successive frames, whatever the payload holds.

Once lock is held, every frame with good markers is descrambled, inverted back when its overhead says so, and split into a 24-bit data word or a pair of sync flags, depending on the data-enable overhead bit. The result is presented for one cycle with a valid strobe. A frame with a bad marker pair while locked gives a one-cycle error pulse. Four such frames in a row drop lock and restart the search.

Top module: `frame_lock_rx`

## Requirements
- R1: A frame is 28 bits sent in this order: start marker (1), inversion flag, data-enable flag, data bits 23 down to 0, end marker (0). Lock is reached on random payload content with no training pattern.
- R2: While unlocked, lockOut rises only at the check of the 8th consecutive frame whose markers are correct at one offset, and never earlier. lockOut changes only on a frame check. The check of a frame is visible one cycle after the cycle in which its last bit is sampled.
- R3: Each failed marker check during the search moves the candidate offset by one bit. After a bit slip of arbitrary length the block locks again on the true frame boundary.
- R4: While locked, a frame with a wrong start or end marker gives a one-cycle errOut pulse and no validOut, and lock is kept for up to 3 such frames in a row.
- R5: The 4th consecutive bad frame while locked drops lockOut, with errOut pulsing in the same cycle. The search then restarts with zero hits, so 8 further good frames relock.
- R6: Descrambling uses a 16-bit LFSR whose next state is {s[14:0], s15^s13^s12^s10}. It is reseeded to 0xFFFF when lock is acquired and advances once at every locked frame check, good or bad. Data bit i is XORed with s[i mod 16]. The first frame output after lock uses the seed.
- R7: When the inversion flag is 1, the descrambled 24 bits are complemented before decoding.
- R8: When data-enable is 1, dataOut carries the word, deOut is 1, and vsOut and hsOut are 0. When data-enable is 0, vsOut takes bit 1 and hsOut takes bit 0 of the processed word, dataOut is 0, and deOut is 0.
- R9: validOut is a one-cycle pulse for each good frame while locked, and it never appears outside a frame check.
- R10: While validOut is low (in particular while unlocked), dataOut, vsOut, hsOut and deOut hold their last values, and neither validOut nor errOut is raised while unlocked.
- R11: After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast bit clock |
| rstN | input | 1 | Asynchronous active-low reset |
| serIn | input | 1 | Serial line bit, one per cycle |
| dataOut | output | 24 | Recovered data word |
| vsOut | output | 1 | Vertical sync |
| hsOut | output | 1 | Horizontal sync |
| deOut | output | 1 | Data enable |
| validOut | output | 1 | One-cycle strobe per recovered frame |
| lockOut | output | 1 | Frame lock held |
| errOut | output | 1 | One-cycle marker error pulse while locked |

## Verification
The bench builds the block with its default parameters: a 24-bit word, eight hits to lock, four misses to unlock and an all-ones seed. With these values a full acquisition takes only a few hundred cycles. That leaves room for one run to cover the initial search from a random offset, isolated and triple marker errors, an exact four-frame unlock followed by an exact eight-frame relock, and a recovery from a five-bit slip. Random payloads set the inversion and data-enable flags in all four combinations, so both decode paths and the complement step are compared against a model frame by frame.

// File: rtl/flr_pkg.sv
package flr_pkg;
  localparam int unsigned LFSR_W = 16;

  typedef struct packed {
    logic capture;
    logic step;
    logic reseed;
  } flrStrobe_t;
endpackage

// File: rtl/flr_ctrl.sv
module flr_ctrl import flr_pkg::*; #(
  parameter int unsigned FRAME_W       = 28,
  parameter int unsigned LOCK_HITS     = 8,
  parameter int unsigned UNLOCK_MISSES = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       markerOk,
  output flrStrobe_t strobe,
  output logic       lockQ,
  output logic       errQ
);
  localparam int unsigned PH_W   = $clog2(FRAME_W);
  localparam int unsigned HIT_W  = $clog2(LOCK_HITS + 1);
  localparam int unsigned MISS_W = $clog2(UNLOCK_MISSES + 1);
  localparam logic [PH_W-1:0]   LAST_PH   = PH_W'(FRAME_W - 1);
  localparam logic [HIT_W-1:0]  LAST_HIT  = HIT_W'(LOCK_HITS - 1);
  localparam logic [MISS_W-1:0] LAST_MISS = MISS_W'(UNLOCK_MISSES - 1);

  logic [PH_W-1:0]   phaseCnt;
  logic [HIT_W-1:0]  hitCnt;
  logic [MISS_W-1:0] missCnt;
  logic              frameEnd;

  assign frameEnd = (phaseCnt == LAST_PH);

  always_comb begin
    strobe.capture = frameEnd & lockQ & markerOk;
    strobe.step    = frameEnd & lockQ;
    strobe.reseed  = frameEnd & ~lockQ & markerOk & (hitCnt == LAST_HIT);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseCnt <= '0;
      hitCnt   <= '0;
      missCnt  <= '0;
      lockQ    <= 1'b0;
      errQ     <= 1'b0;
    end else begin
      errQ <= frameEnd & lockQ & ~markerOk;
      if (!frameEnd) begin
        phaseCnt <= phaseCnt + 1'b1;
      end else if (!lockQ) begin
        if (markerOk) begin
          phaseCnt <= '0;
          if (hitCnt == LAST_HIT) begin
            lockQ   <= 1'b1;
            hitCnt  <= '0;
            missCnt <= '0;
          end else begin
            hitCnt <= hitCnt + 1'b1;
          end
        end else begin
          // slip: hold phase so the next cycle tests the next offset
          hitCnt <= '0;
        end
      end else begin
        phaseCnt <= '0;
        if (markerOk) begin
          missCnt <= '0;
        end else if (missCnt == LAST_MISS) begin
          lockQ   <= 1'b0;
          missCnt <= '0;
          hitCnt  <= '0;
        end else begin
          missCnt <= missCnt + 1'b1;
        end
      end
    end
  end

  a_r2_lock_after_hits: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lockQ) |-> ($past(hitCnt) == LAST_HIT));

  a_r5_drop_after_misses: assert property (@(posedge clk) disable iff (!rstN)
    $fell(lockQ) |-> (($past(missCnt) == LAST_MISS) && errQ));

  a_r4_err_only_locked: assert property (@(posedge clk) disable iff (!rstN)
    errQ |-> $past(lockQ));
endmodule

// File: rtl/flr_datapath.sv
module flr_datapath import flr_pkg::*; #(
  parameter int unsigned       DATA_W = 24,
  parameter logic [LFSR_W-1:0] SEED   = 16'hFFFF
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              serIn,
  input  flrStrobe_t        strobe,
  output logic              markerOk,
  output logic [DATA_W-1:0] dataQ,
  output logic              vsQ,
  output logic              hsQ,
  output logic              deQ,
  output logic              validQ
);
  localparam int unsigned FRAME_W = DATA_W + 4;

  logic [FRAME_W-1:0] shiftQ;
  logic [LFSR_W-1:0]  lfsrQ;
  logic [LFSR_W-1:0]  lfsrNext;
  logic [DATA_W-1:0]  mask;
  logic [DATA_W-1:0]  rawData;
  logic [DATA_W-1:0]  cleanData;
  logic               invFlag;
  logic               deFlag;
  logic [DATA_W-1:0]  nextData;
  logic               nextVs;
  logic               nextHs;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shiftQ <= '0;
    else       shiftQ <= {shiftQ[FRAME_W-2:0], serIn};
  end

  assign markerOk = shiftQ[FRAME_W-1] & ~shiftQ[0];
  assign invFlag  = shiftQ[FRAME_W-2];
  assign deFlag   = shiftQ[FRAME_W-3];
  assign rawData  = shiftQ[DATA_W:1];

  assign lfsrNext = {lfsrQ[LFSR_W-2:0], lfsrQ[15] ^ lfsrQ[13] ^ lfsrQ[12] ^ lfsrQ[10]};

  for (genvar i = 0; i < DATA_W; i++) begin : g_mask
    assign mask[i] = lfsrQ[i % LFSR_W];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              lfsrQ <= SEED;
    else if (strobe.reseed) lfsrQ <= SEED;
    else if (strobe.step)   lfsrQ <= lfsrNext;
  end

  always_comb begin
    cleanData = rawData ^ mask;
    if (invFlag) cleanData = ~cleanData;
    if (deFlag) begin
      nextData = cleanData;
      nextVs   = 1'b0;
      nextHs   = 1'b0;
    end else begin
      nextData = '0;
      nextVs   = cleanData[1];
      nextHs   = cleanData[0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataQ  <= '0;
      vsQ    <= 1'b0;
      hsQ    <= 1'b0;
      deQ    <= 1'b0;
      validQ <= 1'b0;
    end else begin
      validQ <= strobe.capture;
      if (strobe.capture) begin
        dataQ <= nextData;
        vsQ   <= nextVs;
        hsQ   <= nextHs;
        deQ   <= deFlag;
      end
    end
  end

  a_r6_reseed_value: assert property (@(posedge clk) disable iff (!rstN)
    strobe.reseed |=> (lfsrQ == SEED));

  a_r6_never_stuck: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.step && !strobe.reseed) |=> (lfsrQ != $past(lfsrQ)));
endmodule

// File: rtl/frame_lock_rx.sv
module frame_lock_rx import flr_pkg::*; #(
  parameter int unsigned       DATA_W        = 24,
  parameter int unsigned       LOCK_HITS     = 8,
  parameter int unsigned       UNLOCK_MISSES = 4,
  parameter logic [LFSR_W-1:0] SEED          = 16'hFFFF
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              serIn,
  output logic [DATA_W-1:0] dataOut,
  output logic              vsOut,
  output logic              hsOut,
  output logic              deOut,
  output logic              validOut,
  output logic              lockOut,
  output logic              errOut
);
  localparam int unsigned FRAME_W = DATA_W + 4;

  flrStrobe_t strobe;
  logic       markerOk;

  flr_ctrl #(
    .FRAME_W(FRAME_W), .LOCK_HITS(LOCK_HITS), .UNLOCK_MISSES(UNLOCK_MISSES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .markerOk(markerOk),
    .strobe(strobe), .lockQ(lockOut), .errQ(errOut)
  );

  flr_datapath #(.DATA_W(DATA_W), .SEED(SEED)) u_dp (
    .clk(clk), .rstN(rstN), .serIn(serIn), .strobe(strobe),
    .markerOk(markerOk), .dataQ(dataOut), .vsQ(vsOut), .hsQ(hsOut),
    .deQ(deOut), .validQ(validOut)
  );

  a_r9_valid_needs_lock: assert property (@(posedge clk) disable iff (!rstN)
    validOut |-> lockOut);

  a_r4_valid_err_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({validOut, errOut}));

  a_r10_hold_outputs: assert property (@(posedge clk) disable iff (!rstN)
    !validOut |-> ($stable(dataOut) && $stable(deOut) && $stable(vsOut) && $stable(hsOut)));
endmodule

// File: tb/sim_frame_lock_rx.sv
module sim_frame_lock_rx;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W     = 24;
  localparam int FRAME_W    = DATA_W + 4;
  localparam int MAX_FR     = 2048;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic serIn = 1'b0;
  logic [DATA_W-1:0] dataOut;
  logic vsOut, hsOut, deOut, validOut, lockOut, errOut;

  frame_lock_rx u0 (
    .clk(clk), .rstN(rstN), .serIn(serIn), .dataOut(dataOut), .vsOut(vsOut),
    .hsOut(hsOut), .deOut(deOut), .validOut(validOut), .lockOut(lockOut), .errOut(errOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  logic [25:0] payMem [MAX_FR];
  bit          goodMem[MAX_FR];
  int frameCnt = 0;
  int d1 = -1;
  int d2 = -1;
  bit settling = 1;
  bit lockPrev = 0;
  logic [DATA_W-1:0] dataPrev = '0;
  logic [15:0] model = 16'hFFFF;
  int goodRun = 0;
  int missRun = 0;
  int lockRises = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] lfsrStep(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  // returns {de, vs, hs, data}
  function automatic logic [26:0] expOut(input logic [25:0] p, input logic [15:0] s);
    logic [23:0] d;
    for (int i = 0; i < DATA_W; i++) d[i] = p[i] ^ s[i % 16];
    if (p[25]) d = ~d;
    if (p[24]) return {1'b1, 1'b0, 1'b0, d};
    return {1'b0, d[1], d[0], 24'h0};
  endfunction

  task automatic observe();
    int ev;
    logic [26:0] e;
    string tag;
    ev = d2;
    if (!validOut) check(dataOut == dataPrev, "R10 hold while no strobe", 32'(dataOut), 32'(dataPrev));
    if (settling) begin
      if (lockOut && !lockPrev) begin
        check(ev >= 0, "R3 lock lands on true boundary", ev, 0);
        if (lockRises == 0) check(ev >= 7, "R2 lock not before 8 frames", ev, 7);
        settling = 0; model = 16'hFFFF; missRun = 0; goodRun = 0; lockRises++;
      end
    end else if (ev >= 0 && lockPrev) begin
      check(validOut == goodMem[ev], "R9 strobe per good frame", 32'(validOut), 32'(goodMem[ev]));
      check(errOut == !goodMem[ev], "R4 error pulse on bad marker", 32'(errOut), 32'(!goodMem[ev]));
      if (goodMem[ev]) begin
        missRun = 0;
        check(lockOut == 1'b1, "R4 lock kept on good frame", 32'(lockOut), 1);
        e = expOut(payMem[ev], model);
        if (!payMem[ev][24]) tag = "R8 sync decode";
        else if (payMem[ev][25]) tag = "R7 inversion";
        else tag = "R6 descramble";
        check({deOut, vsOut, hsOut, dataOut} == e, tag, 32'({deOut, vsOut, hsOut, dataOut}), 32'(e));
      end else begin
        missRun++;
        if (missRun >= 4) begin
          check(lockOut == 1'b0, "R5 lock drops on 4th miss", 32'(lockOut), 0);
          missRun = 0; goodRun = 0;
        end else begin
          check(lockOut == 1'b1, "R4 lock kept on isolated miss", 32'(lockOut), 1);
        end
      end
      model = lfsrStep(model);
    end else if (ev >= 0) begin
      check(!validOut && !errOut, "R10 no strobes while unlocked", 32'({validOut, errOut}), 0);
      if (goodMem[ev]) goodRun++; else goodRun = 0;
      check(lockOut == (goodRun >= 8), "R2 relock on 8th good frame", 32'(lockOut), 32'(goodRun >= 8));
      if (lockOut) begin model = 16'hFFFF; goodRun = 0; lockRises++; end
    end else begin
      check(!validOut && !errOut, "R9 no strobe off boundary", 32'({validOut, errOut}), 0);
      check(lockOut == lockPrev, "R2 lock moves only at checks", 32'(lockOut), 32'(lockPrev));
    end
    lockPrev = lockOut;
    dataPrev = dataOut;
  endtask

  task automatic sendBit(input logic b, input bit last, input int idx);
    @(negedge clk);
    observe();
    serIn = b;
    d2 = d1;
    d1 = last ? idx : -1;
  endtask

  task automatic sendFrame(input logic [25:0] p, input bit bad1, input bit bad0);
    int idx;
    idx = frameCnt;
    frameCnt++;
    payMem[idx] = p;
    goodMem[idx] = !bad1 && !bad0;
    sendBit(bad1 ? 1'b0 : 1'b1, 0, idx);
    for (int i = 25; i >= 0; i--) sendBit(p[i], 0, idx);
    sendBit(bad0 ? 1'b1 : 1'b0, 1, idx);
  endtask

  function automatic logic [25:0] rnd();
    return 26'($urandom());
  endfunction

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    int seedDummy;
    seedDummy = $urandom(32'd20240);
    repeat (4) @(negedge clk);
    check({dataOut, vsOut, hsOut, deOut, validOut, lockOut, errOut} == '0, "R11 reset state",
          32'({dataOut, vsOut, hsOut, deOut}), 0);
    rstN = 1'b1;
    // unknown offset: random junk then random frames
    repeat (11) sendBit(1'($urandom()), 0, 0);
    repeat (40) sendFrame(rnd(), 0, 0);
    check(lockOut == 1'b1, "R1 lock on random payload", 32'(lockOut), 1);
    // isolated and triple errors
    repeat (5) sendFrame(rnd(), 0, 0);
    sendFrame(rnd(), 1, 0);
    repeat (6) sendFrame(rnd(), 0, 0);
    sendFrame(rnd(), 0, 1);
    repeat (6) sendFrame(rnd(), 0, 0);
    repeat (3) sendFrame(rnd(), 0, 1);
    repeat (10) sendFrame(rnd(), 0, 0);
    check(lockOut == 1'b1, "R4 lock survives three misses", 32'(lockOut), 1);
    // four misses drop lock, then exact relock
    sendFrame(rnd(), 1, 0);
    sendFrame(rnd(), 0, 1);
    sendFrame(rnd(), 1, 1);
    sendFrame(rnd(), 0, 1);
    repeat (12) sendFrame(rnd(), 0, 0);
    check(lockRises == 2, "R5 search restarts and relocks", lockRises, 2);
    // bit slip
    settling = 1;
    repeat (5) sendBit(1'($urandom()), 0, 0);
    repeat (60) sendFrame(rnd(), 0, 0);
    check(lockOut == 1'b1 && lockRises == 3, "R3 recovers from slip", lockRises, 3);
    // random run with sparse isolated errors
    for (int k = 0; k < 200; k++) sendFrame(rnd(), 0, (k % 17) == 9);
    repeat (2) sendFrame(rnd(), 0, 0);
    summary();
  end
endmodule